// File: doc/BRIEF.md
# Vertical Refocusing Line Combiner

This block performs the second, vertical pass of a two-pass refocusing pipeline for micro-lens light-field video. The horizontal pass has already combined pixels within each sensor line. Several of those processed lines are then presented side by side, one pixel column per beat. The block blends the same column across the lines with an equal-weight average, so the vertical pass needs no frame store. Each column result is computed from the lines present in its own beat, and the block returns one blended pixel per input beat.

Inside, lane k of the parallel line bundle is delayed by k beats. Because of this stagger, each of a small ring of per-column accumulators receives exactly one lane value per beat. A beat counter steers the lanes into the ring. A shift code picks which lines take part in the average. It works like the switch pattern of the horizontal stage and sets the depth of the synthesized focal plane. The division by the tap count is a constant reciprocal multiply, or a plain shift when the tap count is a power of two. The result is registered at the output.

Top module: `vert_refocus_filter`

## Requirements
- R1: With shift code 1, each output pixel is floor((L0 + L1 + ... + L(TAPS-1)) / TAPS). Here Lk is the lane-k pixel of the same input beat, and lane k sits at in_rows[k*PIX_W +: PIX_W] and carries line y-k.
- R2: With shift code 0, every tap reads lane 0, so the output equals the lane-0 pixel of the beat.
- R3: The shift code is captured on a beat with in_line_start high and applies from that beat on. A change of in_shift on any other beat has no effect on the output until the next line-start beat.
- R4: The result for input beat c appears on the outputs in the cycle after the clock edge of valid beat c+TAPS-1. Idle cycles (in_valid low) stall the pipeline without losing or mixing data.
- R5: out_valid is high for exactly one cycle after each valid beat, except after the first TAPS-1 valid beats following reset, which produce nothing.
- R6: out_line_start accompanies a column whose index is 0. The column counter is forced to 0 by in_line_start and otherwise wraps from LINE_W-1 to 0.
- R7: In a cycle after an idle clock edge, out_valid is low and out_pix and out_line_start keep their previous values.
- R8: During and right after reset, out_valid, out_line_start and out_pix are all 0.
- R9: For shift code s, tap i (0 <= i < TAPS) reads lane min(i*s, TAPS-1). The output is floor(sum of the TAPS tap values / TAPS), so a lane can count more than once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A column of parallel line pixels is present this cycle |
| in_line_start | input | 1 | This beat is column 0 of a new line; also captures in_shift |
| in_shift | input | SHIFT_W | Focal-plane shift code |
| in_rows | input | TAPS*PIX_W | One pixel per lane; lane k holds line y-k |
| out_valid | output | 1 | A blended pixel is presented this cycle |
| out_line_start | output | 1 | The presented pixel belongs to column 0 |
| out_pix | output | PIX_W | Blended output pixel |

## Verification
The hardest situation to reach is a column still in flight in the skew lanes while a new line-start arrives carrying a different shift code. That column must finish with its own line's code, not the new one. The stimulus forces this in three ways: it restarts lines early, mid-line, with a different code; it toggles in_shift between line starts; and it scatters idle cycles among beats so that the in-flight columns are held across gaps. Saturated and zero pixels are mixed in to stress the reciprocal scaling at both ends of its range.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

   // Number of taps that land on a given lane for a given shift code:
   // tap i reads lane min(i*shift, taps-1).
   function automatic int unsigned tap_weight(input int unsigned lane,
                                              input int unsigned shift,
                                              input int unsigned taps);
      int unsigned n;
      int unsigned r;
      n = 0;
      for (int unsigned i = 0; i < taps; i++) begin
         r = i * shift;
         if (r > taps - 1) r = taps - 1;
         if (r == lane) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/vrf_skew_line.sv
module vrf_skew_line #(
   parameter int PIX_W   = 8,
   parameter int TAPS    = 3,
   parameter int SHIFT_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic [TAPS*PIX_W-1:0]   rows_in,
   input  logic [SHIFT_W-1:0]      shift_in,
   input  logic                    mark_in,
   output logic [TAPS*PIX_W-1:0]   lanes_out,
   output logic [TAPS*SHIFT_W-1:0] shifts_out,
   output logic                    mark_out
);
   localparam int DEPTH = TAPS - 1;

   // shared side pipeline: shift code and column-0 mark travel with the beat
   logic [SHIFT_W-1:0] shift_dly [DEPTH];
   logic               mark_dly  [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            shift_dly[i] <= '0;
            mark_dly[i]  <= 1'b0;
         end
      end else if (adv) begin
         shift_dly[0] <= shift_in;
         mark_dly[0]  <= mark_in;
         for (int i = 1; i < DEPTH; i++) begin
            shift_dly[i] <= shift_dly[i-1];
            mark_dly[i]  <= mark_dly[i-1];
         end
      end
   end

   assign mark_out                 = mark_dly[DEPTH-1];
   assign lanes_out[0 +: PIX_W]    = rows_in[0 +: PIX_W];
   assign shifts_out[0 +: SHIFT_W] = shift_in;

   for (genvar k = 1; k < TAPS; k++) begin : g_lane
      logic [PIX_W-1:0] dly [k];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < k; i++) dly[i] <= '0;
         end else if (adv) begin
            dly[0] <= rows_in[k*PIX_W +: PIX_W];
            for (int i = 1; i < k; i++) dly[i] <= dly[i-1];
         end
      end
      assign lanes_out[k*PIX_W +: PIX_W]    = dly[k-1];
      assign shifts_out[k*SHIFT_W +: SHIFT_W] = shift_dly[k-1];
   end

endmodule

// File: rtl/vrf_accum_bank.sv
module vrf_accum_bank #(
   parameter int PIX_W   = 8,
   parameter int TAPS    = 3,
   parameter int SHIFT_W = 2,
   parameter int SUM_W   = 10,
   parameter int SLOT_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic [SLOT_W-1:0]       slot,
   input  logic [TAPS*PIX_W-1:0]   lane_pix,
   input  logic [TAPS*SHIFT_W-1:0] lane_shift,
   output logic [SUM_W-1:0]        done_sum
);
   logic [SUM_W-1:0] prod   [TAPS];
   logic [SUM_W-1:0] acc_q  [TAPS];
   logic [SUM_W-1:0] acc_nx [TAPS];

   for (genvar k = 0; k < TAPS; k++) begin : g_prod
      assign prod[k] = SUM_W'(vrf_pkg::tap_weight(k, 32'(lane_shift[k*SHIFT_W +: SHIFT_W]), TAPS))
                     * SUM_W'(lane_pix[k*PIX_W +: PIX_W]);
   end

   // demux: accumulator j takes lane (slot - j) mod TAPS this beat
   always_comb begin
      done_sum = '0;
      for (int j = 0; j < TAPS; j++) begin
         int kk;
         kk = (int'(slot) + TAPS - j) % TAPS;
         acc_nx[j] = acc_q[j];
         for (int k = 0; k < TAPS; k++) begin
            if (k == kk) acc_nx[j] = (k == 0) ? prod[k] : acc_q[j] + prod[k];
         end
         if (kk == TAPS - 1) done_sum = acc_nx[j];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < TAPS; j++) acc_q[j] <= '0;
      end else if (adv) begin
         for (int j = 0; j < TAPS; j++) acc_q[j] <= acc_nx[j];
      end
   end

endmodule

// File: rtl/vrf_scaler.sv
module vrf_scaler #(
   parameter int PIX_W = 8,
   parameter int TAPS  = 3,
   parameter int SUM_W = 10
) (
   input  logic [SUM_W-1:0] sum,
   output logic [PIX_W-1:0] quo
);
   localparam int LOG_T = $clog2(TAPS);

   if ((TAPS & (TAPS - 1)) == 0) begin : g_pow2
      assign quo = PIX_W'(sum >> LOG_T);
   end else begin : g_recip
      localparam int FRAC = SUM_W + 2*LOG_T + 1;
      localparam int RW   = FRAC + 1;
      localparam longint unsigned RECIP = ((64'd1 << FRAC) + 64'(TAPS) - 64'd1) / 64'(TAPS);
      if (FRAC > 62) begin : g_bad_frac
         $error("vrf_scaler: reciprocal precision too wide");
      end
      logic [SUM_W+RW-1:0] prod;
      assign prod = (SUM_W+RW)'(sum) * (SUM_W+RW)'(RECIP);
      assign quo  = PIX_W'(prod >> FRAC);
   end

endmodule

// File: rtl/vert_refocus_filter.sv
module vert_refocus_filter #(
   parameter int PIX_W   = 8,
   parameter int TAPS    = 3,
   parameter int LINE_W  = 8,
   parameter int SHIFT_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_line_start,
   input  logic [SHIFT_W-1:0]    in_shift,
   input  logic [TAPS*PIX_W-1:0] in_rows,
   output logic                  out_valid,
   output logic                  out_line_start,
   output logic [PIX_W-1:0]      out_pix
);
   localparam int SUM_W  = PIX_W + $clog2(TAPS);
   localparam int SLOT_W = $clog2(TAPS);
   localparam int COL_W  = (LINE_W > 1) ? $clog2(LINE_W) : 1;

   if (TAPS < 2) begin : g_bad_taps
      $error("vert_refocus_filter: TAPS must be at least 2");
   end
   if (LINE_W < 1) begin : g_bad_line
      $error("vert_refocus_filter: LINE_W must be positive");
   end
   if (PIX_W < 1) begin : g_bad_pix
      $error("vert_refocus_filter: PIX_W must be positive");
   end

   logic [SHIFT_W-1:0]      shift_lat;
   logic [SHIFT_W-1:0]      shift_eff;
   logic [COL_W-1:0]        col_q, col_eff;
   logic [SLOT_W-1:0]       slot_q;
   logic [SLOT_W-1:0]       warm_q;
   logic                    warm_done;
   logic [TAPS*PIX_W-1:0]   lanes;
   logic [TAPS*SHIFT_W-1:0] lane_shifts;
   logic                    mark_tail;
   logic [SUM_W-1:0]        col_sum;
   logic [PIX_W-1:0]        col_mean;

   assign shift_eff = in_line_start ? in_shift : shift_lat;
   assign col_eff   = in_line_start ? '0 : col_q;
   assign warm_done = (warm_q == SLOT_W'(TAPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_lat <= '0;
         col_q     <= '0;
         slot_q    <= '0;
         warm_q    <= '0;
      end else if (in_valid) begin
         shift_lat <= shift_eff;
         col_q     <= (col_eff == COL_W'(LINE_W - 1)) ? '0 : col_eff + 1'b1;
         slot_q    <= (slot_q == SLOT_W'(TAPS - 1)) ? '0 : slot_q + 1'b1;
         if (!warm_done) warm_q <= warm_q + 1'b1;
      end
   end

   vrf_skew_line #(.PIX_W(PIX_W), .TAPS(TAPS), .SHIFT_W(SHIFT_W)) u_skew (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (in_valid),
      .rows_in    (in_rows),
      .shift_in   (shift_eff),
      .mark_in    (col_eff == '0),
      .lanes_out  (lanes),
      .shifts_out (lane_shifts),
      .mark_out   (mark_tail)
   );

   vrf_accum_bank #(.PIX_W(PIX_W), .TAPS(TAPS), .SHIFT_W(SHIFT_W),
                    .SUM_W(SUM_W), .SLOT_W(SLOT_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (in_valid),
      .slot       (slot_q),
      .lane_pix   (lanes),
      .lane_shift (lane_shifts),
      .done_sum   (col_sum)
   );

   vrf_scaler #(.PIX_W(PIX_W), .TAPS(TAPS), .SUM_W(SUM_W)) u_scale (
      .sum (col_sum),
      .quo (col_mean)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_line_start <= 1'b0;
         out_pix        <= '0;
      end else begin
         out_valid <= in_valid && warm_done;
         if (in_valid && warm_done) begin
            out_pix        <= col_mean;
            out_line_start <= mark_tail;
         end
      end
   end

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
   parameter int PIX_W = 8,
   parameter int TAPS  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic             out_line_start,
   input logic [PIX_W-1:0] out_pix
);
   localparam int CW = $clog2(TAPS + 1);
   logic [CW-1:0] beats;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beats <= '0;
      else if (in_valid && beats != CW'(TAPS)) beats <= beats + 1'b1;
   end

   assert_valid_follows_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_no_early_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (beats == CW'(TAPS)));

   assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_pix) && $stable(out_line_start)));

   assert_marker_with_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_line_start) |-> out_valid);

endmodule

bind vert_refocus_filter vrf_checker #(.PIX_W(PIX_W), .TAPS(TAPS)) u_vrf_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .out_valid      (out_valid),
   .out_line_start (out_line_start),
   .out_pix        (out_pix)
);

// File: tb/vert_refocus_filter_bench.sv
module vert_refocus_filter_bench;
   localparam int PIX_W   = 8;
   localparam int TAPS    = 3;
   localparam int LINE_W  = 8;
   localparam int SHIFT_W = 2;
   localparam int MAXP    = (1 << PIX_W) - 1;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic                  in_line_start = 1'b0;
   logic [SHIFT_W-1:0]    in_shift = '0;
   logic [TAPS*PIX_W-1:0] in_rows = '0;
   logic                  out_valid;
   logic                  out_line_start;
   logic [PIX_W-1:0]      out_pix;

   always #4 clk = ~clk;

   vert_refocus_filter #(.PIX_W(PIX_W), .TAPS(TAPS), .LINE_W(LINE_W), .SHIFT_W(SHIFT_W))
   u_vert_refocus_filter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line_start(in_line_start),
      .in_shift(in_shift), .in_rows(in_rows), .out_valid(out_valid),
      .out_line_start(out_line_start), .out_pix(out_pix));

   int    n_checks = 0;
   int    n_fail   = 0;
   string tag      = "R8";
   bit    finished = 0;

   // reference state
   int exp_pix = 0;
   bit exp_vld = 0;
   bit exp_ls  = 0;
   int q_pix[$];
   bit q_ls[$];
   int shift_lat = 0;
   int col = 0;

   task automatic check_outputs();
      string ptag;
      ptag = exp_vld ? tag : "R7";
      n_checks++;
      if (out_valid !== exp_vld) begin
         n_fail++;
         $display("FAIL R5 out_valid actual=%0b expected=%0b (phase %s)", out_valid, exp_vld, tag);
      end
      n_checks++;
      if (int'(out_pix) != exp_pix) begin
         n_fail++;
         $display("FAIL %s out_pix actual=%0d expected=%0d", ptag, out_pix, exp_pix);
      end
      n_checks++;
      if (out_line_start !== exp_ls) begin
         n_fail++;
         $display("FAIL R6 out_line_start actual=%0b expected=%0b (phase %s)", out_line_start, exp_ls, tag);
      end
   endtask

   // mode: 0 random, 1 all max, 2 all zero, 3 lane-distinct ramp
   task automatic beat(input bit v, input bit ls, input int sh, input int mode);
      int rows[TAPS];
      int eff, ce, sum, r;
      @(negedge clk);
      check_outputs();
      for (int k = 0; k < TAPS; k++) begin
         case (mode)
            1: rows[k] = MAXP;
            2: rows[k] = 0;
            3: rows[k] = (k * 37 + col * 11) & MAXP;
            default: rows[k] = int'($urandom_range(MAXP, 0));
         endcase
         in_rows[k*PIX_W +: PIX_W] = PIX_W'(rows[k]);
      end
      in_valid      = v;
      in_line_start = ls;
      in_shift      = SHIFT_W'(sh);
      exp_vld = 0;
      if (v) begin
         eff = ls ? sh : shift_lat;
         if (ls) shift_lat = sh;
         ce  = ls ? 0 : col;
         col = (ce == LINE_W - 1) ? 0 : ce + 1;
         sum = 0;
         for (int i = 0; i < TAPS; i++) begin
            r = i * eff;
            if (r > TAPS - 1) r = TAPS - 1;
            sum += rows[r];
         end
         q_pix.push_back(sum / TAPS);
         q_ls.push_back(ce == 0);
         if (q_pix.size() == TAPS) begin
            exp_pix = q_pix.pop_front();
            exp_ls  = q_ls.pop_front();
            exp_vld = 1;
         end
      end
   endtask

   task automatic line(input int sh, input int mode, input int gap_pct);
      for (int x = 0; x < LINE_W; x++) begin
         while (gap_pct > 0 && int'($urandom_range(99, 0)) < gap_pct)
            beat(0, 0, int'($urandom_range(3, 0)), 0);
         beat(1, x == 0, sh, mode);
      end
   endtask

   initial begin
      // R8: reset state
      repeat (3) begin
         @(negedge clk);
         n_checks++;
         if (out_valid !== 1'b0 || out_line_start !== 1'b0 || out_pix !== '0) begin
            n_fail++;
            $display("FAIL R8 reset outputs actual=%0b/%0b/%0d expected=0/0/0",
                     out_valid, out_line_start, out_pix);
         end
      end
      rst_n = 1'b1;
      tag = "R8";
      beat(0, 0, 0, 0);

      tag = "R1";   // shift 1, mean over all lanes, includes warm-up (R5)
      line(1, 3, 0);
      line(1, 0, 0);
      line(1, 1, 0);
      line(1, 2, 0);

      tag = "R2";   // shift 0 passes lane 0
      line(0, 0, 0);
      line(0, 3, 0);

      tag = "R9";   // clamped strides
      line(2, 0, 0);
      line(3, 0, 0);
      line(2, 1, 0);
      line(3, 3, 0);

      tag = "R3";   // in_shift changes without line start are ignored
      for (int x = 0; x < LINE_W; x++) beat(1, x == 0, (x == 0) ? 1 : (x % 4), 0);
      for (int x = 0; x < LINE_W; x++) beat(1, x == 0, (x == 0) ? 0 : 3, 0);

      tag = "R4";   // idle gaps stall the pipeline
      line(1, 0, 40);
      line(2, 0, 60);
      line(0, 0, 30);

      tag = "R6";   // early restart and wrap without line start
      for (int x = 0; x < 4; x++) beat(1, x == 0, 1, 0);
      for (int x = 0; x < LINE_W + 3; x++) beat(1, x == 0, 2, 0);
      for (int x = 0; x < LINE_W; x++) beat(1, 0, 3, 0);
      for (int x = 0; x < 5; x++) beat(1, x == 0, 0, 0);

      tag = "R7";
      for (int i = 0; i < 4; i++) beat(0, 0, int'($urandom_range(3, 0)), 0);

      tag = "R1";   // long random mix with flush
      for (int n = 0; n < 30; n++) line(int'($urandom_range(3, 0)), 0, 20);
      for (int i = 0; i < TAPS + 2; i++) beat(1, 0, 0, 0);
      beat(0, 0, 0, 0);
      beat(0, 0, 0, 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule